// File: doc/BRIEF.md
# Byte-wide GPIO port with per-input edge interrupts

The block is a small memory-mapped GPIO port of eight lines behind an 8-bit register bus. The four low lines are fixed outputs and the four high lines are fixed inputs; the direction of a line cannot be changed. Each input passes through a two-flop synchroniser and then feeds an edge detector. The detector keeps one pending latch for rising edges and a separate one for falling edges, and both latch on every edge whatever the configuration says.

A 2-bit trigger field per input decides which of the two latches shows in the status register and drives the single level interrupt towards the parent controller. Software acknowledges a line by writing a one to its status bit. That clears both latches of the line at once, so a handler can flip the trigger between rising and falling without leaving a stale event behind.

Top module: `byte_gpio_irq`

## Requirements
- R1: After reset the output lines drive 0, `irq` is low, and reads return 0x0F at offset 0 and 0x00 at offsets 1, 3 and 4.
- R2: Offset 0 (direction) always reads 0x0F. A set bit marks an output. Writes to it have no effect.
- R3: A write to offset 1 drives `bus_wdata[3:0]` onto `gpio_out` from the next clock. Written bits 7:4 are ignored, and data-register reads return 0 in bits 3:0.
- R4: A read of offset 1 returns in bits 7:4 the input levels after a two-flop synchroniser: `gpio_in[k]` appears in bit k+4.
- R5: Offset 3 is read/write. It holds one 2-bit trigger field per input line, and line L uses bits 2*(L-4)+1 : 2*(L-4).
- R6: Every input keeps its own rising and falling pending latches. Both are set by their edge whatever the trigger field holds, and both stay set until they are cleared.
- R7: Status bit n (offset 4) shows the state of input line n+4. Field value 2'b01 shows the falling latch, 2'b10 shows the rising latch, and 2'b00 and the invalid value 2'b11 show 0. Status bits 7:4 read 0.
- R8: Writing to offset 4 clears both latches of every line whose bit is written as 1. Lines written with 0 keep their latches.
- R9: An edge detected in the same cycle as a clear of its line leaves that edge's latch set.
- R10: `irq` is a level output, high exactly while some status bit is visible (the OR of the visible status bits).
- R11: Offsets 2, 5, 6 and 7 read 0. Writes to them change no register and no output.
- R12: `bus_rdata` is 0 whenever `bus_rd_en` is low. During a read it shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd_en | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd_en is high |
| gpio_in | input | 4 | Asynchronous input pins (lines 4 to 7) |
| gpio_out | output | 4 | Output drivers (lines 0 to 3) |
| irq | output | 1 | Level interrupt to the parent controller |

## Verification
The bench builds the block with its default parameters: four outputs, four inputs and two synchroniser stages. With those values the whole register map is 8 bits wide, so every trigger code of every line and every status bit position can be driven and read back. The two-stage synchroniser fixes the delay from pin to latch at three clock edges. The bench uses that fixed delay to land a new rising edge in exactly the cycle of a status clear.

// File: rtl/byte_gpio_pkg.sv
package byte_gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BAD  = 2'b11
  } trig_sel_e;

  // Which latch a trigger field exposes; off and the invalid code expose nothing.
  function automatic logic pick_visible(input logic [1:0] sel,
                                        input logic rise_p,
                                        input logic fall_p);
    case (trig_sel_e'(sel))
      TRIG_FALL: return fall_p;
      TRIG_RISE: return rise_p;
      default:   return 1'b0;
    endcase
  endfunction

  // Fixed direction pattern: ones for output lines.
  function automatic logic [7:0] dir_pattern(input int unsigned n_out);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) if (i < int'(n_out)) v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic rise_pend_o,
  output logic fall_pend_o
);
  logic prev_q;
  logic rise_ev;
  logic fall_ev;

  assign rise_ev = lvl_i & ~prev_q;
  assign fall_ev = ~lvl_i & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      rise_pend_o <= 1'b0;
      fall_pend_o <= 1'b0;
    end else begin
      prev_q      <= lvl_i;
      rise_pend_o <= rise_ev | (rise_pend_o & ~clr_i);
      fall_pend_o <= fall_ev | (fall_pend_o & ~clr_i);
    end
  end

  assert_rise_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> rise_pend_o);
  assert_fall_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> fall_pend_o);
  assert_rise_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pend_o && !clr_i) |=> rise_pend_o);
  assert_clear_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise_ev && !fall_ev) |=> (!rise_pend_o && !fall_pend_o));
  assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && rise_ev) |=> rise_pend_o);
endmodule

// File: rtl/byte_gpio_irq.sv
module byte_gpio_irq
  import byte_gpio_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 4,
  parameter int unsigned NUM_IN      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr_en,
  input  logic                      bus_rd_en,
  input  logic [NUM_OUT+NUM_IN-1:0] bus_wdata,
  output logic [NUM_OUT+NUM_IN-1:0] bus_rdata,
  input  logic [NUM_IN-1:0]         gpio_in,
  output logic [NUM_OUT-1:0]        gpio_out,
  output logic                      irq
);
  localparam int unsigned BUS_W  = NUM_OUT + NUM_IN;
  localparam int unsigned TRIG_W = 2 * NUM_IN;
  localparam logic [BUS_W-1:0] DIR_VAL = BUS_W'(dir_pattern(NUM_OUT));

  logic [NUM_IN-1:0]  in_lvl;
  logic [NUM_IN-1:0]  rise_p;
  logic [NUM_IN-1:0]  fall_p;
  logic [NUM_IN-1:0]  vis;
  logic [NUM_IN-1:0]  clr;
  logic [TRIG_W-1:0]  trig_q;
  logic [BUS_W-1:0]   rdata_c;

  logic wr_data_hit;
  logic wr_trig_hit;
  logic wr_stat_hit;

  assign wr_data_hit = bus_wr_en && (bus_addr == OFS_DATA);
  assign wr_trig_hit = bus_wr_en && (bus_addr == OFS_TRIG);
  assign wr_stat_hit = bus_wr_en && (bus_addr == OFS_STAT);

  gpio_in_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (gpio_in),
    .lvl_o (in_lvl)
  );

  for (genvar g = 0; g < int'(NUM_IN); g++) begin : g_line
    assign clr[g] = wr_stat_hit & bus_wdata[g];

    gpio_edge_unit edge_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_i       (in_lvl[g]),
      .clr_i       (clr[g]),
      .rise_pend_o (rise_p[g]),
      .fall_pend_o (fall_p[g])
    );

    assign vis[g] = pick_visible(trig_q[2*g +: 2], rise_p[g], fall_p[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_out <= '0;
      trig_q   <= '0;
    end else begin
      if (wr_data_hit) gpio_out <= bus_wdata[NUM_OUT-1:0];
      if (wr_trig_hit) trig_q   <= bus_wdata[TRIG_W-1:0];
    end
  end

  assign irq = |vis;

  always_comb begin
    rdata_c = '0;
    if (bus_rd_en) begin
      case (bus_addr)
        OFS_DIR:  rdata_c = DIR_VAL;
        OFS_DATA: rdata_c = {in_lvl, {NUM_OUT{1'b0}}};
        OFS_TRIG: rdata_c[TRIG_W-1:0] = trig_q;
        OFS_STAT: rdata_c[NUM_IN-1:0] = vis;
        default:  rdata_c = '0;
      endcase
    end
  end
  assign bus_rdata = rdata_c;

  assert_dir_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == OFS_DIR) |-> (bus_rdata == DIR_VAL));
  assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |=> (gpio_out == $past(bus_wdata[NUM_OUT-1:0])));
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_hit |=> $stable(gpio_out));
  assert_status_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == OFS_STAT) |-> (bus_rdata[BUS_W-1:NUM_IN] == '0));
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q == '0) |-> !irq);
  assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |-> (bus_rdata == '0));
endmodule

// File: tb/byte_gpio_irq_tb.sv
module byte_gpio_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr_en = 1'b0;
  logic       bus_rd_en = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] gpio_in = '0;
  logic [3:0] gpio_out;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_gpio_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    #1;
    chk(bus_rdata, exp, tag);
    bus_rd_en = 1'b0;
  endtask

  task automatic pins(input logic [3:0] v);
    @(negedge clk);
    gpio_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk(3'd0, 8'h0F, "R1 dir after reset");
    rd_chk(3'd1, 8'h00, "R1 data after reset");
    rd_chk(3'd3, 8'h00, "R1 trig after reset");
    rd_chk(3'd4, 8'h00, "R1 status after reset");
    chk({7'd0, irq}, 8'h00, "R1 irq after reset");
    chk({4'd0, gpio_out}, 8'h00, "R1 gpio_out after reset");
  endtask

  task automatic t_direction;
    wr(3'd0, 8'hF0);
    rd_chk(3'd0, 8'h0F, "R2 dir ignores write");
  endtask

  task automatic t_data_out;
    wr(3'd1, 8'hA5);
    chk({4'd0, gpio_out}, 8'h05, "R3 output low nibble");
    rd_chk(3'd1, 8'h00, "R3 high write bits ignored");
    wr(3'd1, 8'h3C);
    chk({4'd0, gpio_out}, 8'h0C, "R3 second output");
  endtask

  task automatic t_data_in;
    pins(4'b1010);
    rd_chk(3'd1, 8'hA0, "R4 input 1010");
    pins(4'b0101);
    rd_chk(3'd1, 8'h50, "R4 input 0101");
    pins(4'b0000);
    wr(3'd4, 8'h0F);
    wr(3'd3, 8'h55);
    rd_chk(3'd4, 8'h00, "R8 all cleared");
  endtask

  task automatic t_trig;
    wr(3'd3, 8'hE4);
    rd_chk(3'd3, 8'hE4, "R5 trig readback E4");
    wr(3'd3, 8'h1B);
    rd_chk(3'd3, 8'h1B, "R5 trig readback 1B");
    wr(3'd3, 8'h00);
  endtask

  task automatic t_latches;
    pins(4'b0010);
    pins(4'b0000);
    rd_chk(3'd4, 8'h00, "R7 off hides latches");
    chk({7'd0, irq}, 8'h00, "R10 irq low when off");
    wr(3'd3, 8'h04);
    rd_chk(3'd4, 8'h02, "R6 falling latched while off");
    chk({7'd0, irq}, 8'h01, "R10 irq from falling");
    wr(3'd3, 8'h08);
    rd_chk(3'd4, 8'h02, "R6 rising latched while off");
    wr(3'd3, 8'h0C);
    rd_chk(3'd4, 8'h00, "R7 invalid code shows nothing");
    chk({7'd0, irq}, 8'h00, "R10 irq low on invalid code");
  endtask

  task automatic t_map;
    pins(4'b1000);
    wr(3'd3, 8'h80);
    rd_chk(3'd4, 8'h08, "R7 line7 rising at bit3");
    pins(4'b0000);
  endtask

  task automatic t_w1c;
    wr(3'd4, 8'h02);
    wr(3'd3, 8'h88);
    rd_chk(3'd4, 8'h08, "R8 line5 rise cleared, line7 kept");
    wr(3'd3, 8'h44);
    rd_chk(3'd4, 8'h08, "R8 line5 fall cleared, line7 kept");
    wr(3'd4, 8'h08);
    rd_chk(3'd4, 8'h00, "R8 line7 cleared");
    chk({7'd0, irq}, 8'h00, "R10 irq low after clear");
  endtask

  task automatic t_same_cycle;
    wr(3'd3, 8'h00);
    pins(4'b0001);
    pins(4'b0000);
    @(negedge clk);
    gpio_in = 4'b0001;
    @(negedge clk);
    wr(3'd4, 8'h01);
    repeat (2) @(negedge clk);
    wr(3'd3, 8'h02);
    rd_chk(3'd4, 8'h01, "R9 rising edge survives clear");
    wr(3'd3, 8'h01);
    rd_chk(3'd4, 8'h00, "R9 old falling latch cleared");
    pins(4'b0000);
    wr(3'd4, 8'h0F);
  endtask

  task automatic t_irq;
    wr(3'd3, 8'h20);
    chk({7'd0, irq}, 8'h00, "R10 irq low before edge");
    pins(4'b0100);
    chk({7'd0, irq}, 8'h01, "R10 irq on line6 rise");
    wr(3'd3, 8'h10);
    chk({7'd0, irq}, 8'h00, "R10 irq follows selection");
    wr(3'd3, 8'h20);
    chk({7'd0, irq}, 8'h01, "R10 irq level persists");
  endtask

  task automatic t_unmapped;
    wr(3'd2, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd_chk(3'd2, 8'h00, "R11 offset2 reads 0");
    rd_chk(3'd7, 8'h00, "R11 offset7 reads 0");
    rd_chk(3'd3, 8'h20, "R11 trig untouched");
    rd_chk(3'd4, 8'h04, "R11 status untouched");
    chk({4'd0, gpio_out}, 8'h0C, "R11 outputs untouched");
  endtask

  task automatic t_idle;
    @(negedge clk);
    bus_addr = 3'd0; bus_rd_en = 1'b0;
    #1;
    chk(bus_rdata, 8'h00, "R12 idle read is 0");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_data_out();
    t_data_in();
    t_trig();
    t_latches();
    t_map();
    t_w1c();
    t_same_cycle();
    t_irq();
    t_unmapped();
    t_idle();
    finish_run();
  end
endmodule